// File: doc/BRIEF.md
# Write-Only Two-Wire Configuration Receiver

This block is a slave on a two-wire serial bus. It answers one fixed 7-bit device address, accepts write transfers only, and places the data bytes it receives into a small internal register file. The bus lines are sampled in the system clock domain. The data line is driven through a single pull-low enable, which models an open-drain pad. The stored bytes are presented on a flat parallel bus, and the two low bits of the first byte are decoded into output-mode controls for the clock outputs that follow the block.

A transfer begins with a start condition, which is SDA falling while SCL is high. The address byte follows, and then any number of data bytes. No register index byte is sent. The first data byte always lands in register 0, the next in register 1, and so on. Bytes beyond the last implemented register are acknowledged but not stored. A stop condition, which is SDA rising while SCL is high, ends the transfer. A repeated start begins a new transfer, and the register pointer returns to 0.

Top module: `cfg_serial_slave`

## Requirements
- R1: A start condition, repeated or not, resets the bit count and returns the register pointer to 0, so the next data byte goes to register 0. The pull-low output is released in the cycle after a start.
- R2: An address byte of 1101001 followed by a R/W bit of 0 (bits sent MSB first, R/W as the eighth bit) is acknowledged. The block pulls SDA low for the whole ninth SCL clock.
- R3: An address byte with a different address, or with R/W = 1, is not acknowledged. The data bytes that follow it are not acknowledged, and no register changes.
- R4: Data bytes are received MSB first. They fill registers 0, 1, 2, … in the order sent.
- R5: Each data byte of an accepted transfer is acknowledged in its ninth SCL clock.
- R6: A byte is written only on the SCL falling edge that ends its acknowledge slot. If a stop arrives partway through a byte, that byte is discarded and the bytes already completed are kept.
- R7: Data bytes beyond NUM_REGS are acknowledged and discarded. The register contents do not change.
- R8: Bits 7 to 2 of register 0 always read 0, whatever value was written to them.
- R9: Register 0 bits [1:0] select the output mode. 11 sets `hiz_en`, 01 sets `test_en`, and 00 or 10 clears both. The two outputs are never high together.
- R10: After reset, every register reads 0, both mode outputs are 0 (normal operation), and SDA is released.
- R11: `sda_pull_low` is high only during an acknowledge slot. It is never asserted while the master is sending address or data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line, as read from the pad |
| sda_i | input | 1 | Serial data line, as read from the pad |
| sda_pull_low | output | 1 | Drives the data line low when 1 (open-drain enable) |
| cfg_flat | output | 8*NUM_REGS | Stored registers; register k is at bits [8k+7:8k] |
| hiz_en | output | 1 | Output mode is three-state |
| test_en | output | 1 | Output mode is test |

## Verification
The assertions check properties that hold on every cycle. SDA is pulled low only inside an acknowledge slot, and never while the receiver is skipping a rejected transfer. Commits happen only on an SCL falling edge, and a commit past the last register leaves the stored bytes unchanged. The reserved bits of register 0 stay at zero, and the two mode outputs are never high together. Only the bench scenarios can show the behaviours that depend on the whole transfer: which address and R/W combinations are acknowledged, the MSB-first byte order, the pointer restarting after a repeated start, and the loss of a byte cut short by a stop.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_ADDR = 2'd1,
    RX_DATA = 2'd2,
    RX_SKIP = 2'd3
  } rx_state_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_TEST   = 2'd1,
    MODE_HIZ    = 2'd2
  } out_mode_e;

  // Writable bits of register idx; register 0 keeps only its mode field.
  function automatic logic [7:0] byte_mask(input int unsigned idx);
    return (idx == 0) ? 8'h03 : 8'hFF;
  endfunction

  // Address byte accepted: address field matches and the direction bit requests a write.
  function automatic logic addr_accept(input logic [7:0] rx, input logic [6:0] dev);
    return (rx[7:1] == dev) && !rx[0];
  endfunction

  function automatic out_mode_e mode_of(input logic [7:0] r0);
    case (r0[1:0])
      2'b11:   return MODE_HIZ;
      2'b01:   return MODE_TEST;
      default: return MODE_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RESET_VAL;
      q_o    <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/cfgs_rx.sv
module cfgs_rx
  import cfgs_pkg::*;
#(
  parameter int          NUM_REGS = 4,
  parameter logic [6:0]  DEV_ADDR = 7'b1101001,
  localparam int         IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  output logic             pull_low,
  output logic             start_det,
  output logic             stop_det,
  output logic             scl_fall,
  output logic             ack_window,
  output logic             byte_commit,
  output logic             overflow,
  output logic             rx_skip,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data
);
  logic       scl_q, sda_q;
  logic       scl_rise;
  logic [3:0] bit_cnt;
  logic [7:0] shift_q;
  logic [IDX_W-1:0] idx_q;
  rx_state_e  state_q;
  logic       active;

  assign scl_rise    = scl_s && !scl_q;
  assign scl_fall    = !scl_s && scl_q;
  assign start_det   = scl_s && scl_q && sda_q && !sda_s;
  assign stop_det    = scl_s && scl_q && !sda_q && sda_s;
  assign active      = (state_q == RX_ADDR) || (state_q == RX_DATA);
  assign ack_window  = active && (bit_cnt >= 4'd8);
  assign byte_commit = scl_fall && (state_q == RX_DATA) && (bit_cnt == 4'd9)
                       && !start_det && !stop_det;
  assign overflow    = (idx_q == IDX_W'(NUM_REGS));
  assign rx_skip     = (state_q == RX_SKIP);
  assign wr_idx      = idx_q;
  assign wr_data     = shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= RX_IDLE;
      bit_cnt  <= '0;
      shift_q  <= '0;
      idx_q    <= '0;
      pull_low <= 1'b0;
    end else if (start_det) begin
      state_q  <= RX_ADDR;
      bit_cnt  <= '0;
      idx_q    <= '0;
      pull_low <= 1'b0;
    end else if (stop_det) begin
      state_q  <= RX_IDLE;
      bit_cnt  <= '0;
      pull_low <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_cnt < 4'd8) shift_q <= {shift_q[6:0], sda_s};
        if (bit_cnt < 4'd9) bit_cnt <= bit_cnt + 4'd1;
      end else if (scl_fall) begin
        if (bit_cnt == 4'd8) begin
          pull_low <= (state_q == RX_DATA) || addr_accept(shift_q, DEV_ADDR);
        end else if (bit_cnt == 4'd9) begin
          pull_low <= 1'b0;
          bit_cnt  <= '0;
          if (state_q == RX_ADDR)
            state_q <= pull_low ? RX_DATA : RX_SKIP;
          else if (!overflow)
            idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfgs_regfile.sv
module cfgs_regfile
  import cfgs_pkg::*;
#(
  parameter int  NUM_REGS = 4,
  localparam int IDX_W    = $clog2(NUM_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  output logic [8*NUM_REGS-1:0] cfg_flat,
  output logic                  hiz_en,
  output logic                  test_en
);
  out_mode_e mode;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [7:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        r_q <= '0;
      else if (wr_en && (wr_idx == IDX_W'(g)))
        r_q <= wr_data & byte_mask(g);
    end
    assign cfg_flat[8*g +: 8] = r_q;
  end

  assign mode    = mode_of(cfg_flat[7:0]);
  assign hiz_en  = (mode == MODE_HIZ);
  assign test_en = (mode == MODE_TEST);
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int          NUM_REGS = 4,
  parameter logic [6:0]  DEV_ADDR = 7'b1101001
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_low,
  output logic [8*NUM_REGS-1:0] cfg_flat,
  output logic                  hiz_en,
  output logic                  test_en
);
  localparam int IDX_W = $clog2(NUM_REGS + 1);

  logic [1:0]       line_s;
  logic             start_det, stop_det, scl_fall, ack_window;
  logic             byte_commit, overflow, rx_skip;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;

  cfgs_sync #(.WIDTH(2), .RESET_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(line_s)
  );

  cfgs_rx #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
    .pull_low(sda_pull_low), .start_det(start_det), .stop_det(stop_det),
    .scl_fall(scl_fall), .ack_window(ack_window), .byte_commit(byte_commit),
    .overflow(overflow), .rx_skip(rx_skip), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  cfgs_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(byte_commit && !overflow),
    .wr_idx(wr_idx), .wr_data(wr_data), .cfg_flat(cfg_flat),
    .hiz_en(hiz_en), .test_en(test_en)
  );
endmodule

// File: rtl/cfgs_checker.sv
module cfgs_checker #(
  parameter int NUM_REGS = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  sda_pull_low,
  input logic                  ack_window,
  input logic                  byte_commit,
  input logic                  scl_fall,
  input logic                  start_det,
  input logic                  rx_skip,
  input logic                  overflow,
  input logic [8*NUM_REGS-1:0] cfg_flat,
  input logic                  hiz_en,
  input logic                  test_en
);
  // R11
  ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_low |-> ack_window);

  // R6
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_commit |-> scl_fall);

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_pull_low);

  // R3
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_skip |-> !sda_pull_low);

  // R7
  overflow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_commit && overflow) |=> $stable(cfg_flat));

  // R8
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_flat[7:2] == 6'd0);

  // R9
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hiz_en && test_en));
endmodule

bind cfg_serial_slave cfgs_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull_low(sda_pull_low),
  .ack_window(ack_window), .byte_commit(byte_commit), .scl_fall(scl_fall),
  .start_det(start_det), .rx_skip(rx_skip), .overflow(overflow),
  .cfg_flat(cfg_flat), .hiz_en(hiz_en), .test_en(test_en)
);

// File: tb/test_cfg_serial_slave.sv
module test_cfg_serial_slave;
  localparam int N = 4;
  localparam int Q = 6;
  localparam logic [6:0] DEV = 7'b1101001;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_pull_low, hiz_en, test_en;
  logic [8*N-1:0] cfg_flat;
  wire  sda_line = sda_m & ~sda_pull_low;

  int checks = 0, errors = 0;
  logic [7:0] exp_r [N];
  bit stray;

  always #10 clk = ~clk;

  cfg_serial_slave #(.NUM_REGS(N)) i_cfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_pull_low(sda_pull_low), .cfg_flat(cfg_flat),
    .hiz_en(hiz_en), .test_en(test_en)
  );

  function automatic logic [7:0] keep_bits(int idx);
    return idx == 0 ? 8'b0000_0011 : 8'b1111_1111;
  endfunction

  function automatic logic [8*N-1:0] exp_flat();
    logic [8*N-1:0] f;
    for (int i = 0; i < N; i++) f[8*i +: 8] = exp_r[i];
    return f;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(Q / 2);
      if (sda_pull_low) stray = 1;
      tick(Q - Q / 2); scl_m = 0; tick(Q);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q / 2);
    acked = !sda_line;
    tick(Q - Q / 2); scl_m = 0; tick(Q);
  endtask

  task automatic check_regs(string req);
    check(cfg_flat === exp_flat(), req, 64'(cfg_flat), 64'(exp_flat()));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit ak;
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) exp_r[i] = 8'h00;
    stray = 0;
    tick(5); rst_n = 1; tick(3);

    // R10 reset state
    check(cfg_flat === '0, "R10 regs", 64'(cfg_flat), 0);
    check(!hiz_en && !test_en, "R10 mode", {hiz_en, test_en}, 0);
    check(sda_pull_low === 1'b0, "R10 sda", sda_pull_low, 0);

    // R2 R4 R5 R8 R9: accepted write, reserved bits dropped, three-state mode
    do_start();
    send_byte({DEV, 1'b0}, ak);
    check(ak, "R2 addr ack", ak, 1);
    send_byte(8'hFF, ak); check(ak, "R5 data ack", ak, 1);
    send_byte(8'hA5, ak); check(ak, "R5 data ack", ak, 1);
    do_stop(); tick(4);
    exp_r[0] = 8'hFF & keep_bits(0); exp_r[1] = 8'hA5;
    check_regs("R4 R8 order/reserved");
    check(hiz_en && !test_en, "R9 three-state", {hiz_en, test_en}, 2'b10);

    // R9: test mode 01, then unused code 10 reads as normal
    do_start(); send_byte({DEV, 1'b0}, ak); send_byte(8'h01, ak); do_stop(); tick(4);
    check(test_en && !hiz_en, "R9 test", {hiz_en, test_en}, 2'b01);
    do_start(); send_byte({DEV, 1'b0}, ak); send_byte(8'h02, ak); do_stop(); tick(4);
    check(!test_en && !hiz_en, "R9 unused code", {hiz_en, test_en}, 0);
    exp_r[0] = 8'h02;

    // R3: read request and wrong address are ignored
    do_start(); send_byte({DEV, 1'b1}, ak);
    check(!ak, "R3 read nack", ak, 0);
    send_byte(8'h03, ak); check(!ak, "R3 data nack", ak, 0);
    do_stop(); tick(4);
    check_regs("R3 read unchanged");
    do_start(); send_byte({DEV ^ 7'h01, 1'b0}, ak);
    check(!ak, "R3 addr nack", ak, 0);
    send_byte(8'h03, ak); do_stop(); tick(4);
    check_regs("R3 addr unchanged");

    // R7: overlong write
    do_start(); send_byte({DEV, 1'b0}, ak);
    for (int i = 0; i < N + 2; i++) begin
      logic [7:0] d = 8'(8'h10 + i);
      send_byte(d, ak);
      check(ak, "R7 ack beyond end", ak, 1);
      if (i < N) exp_r[i] = d & keep_bits(i);
    end
    do_stop(); tick(4);
    check_regs("R7 discard beyond end");

    // R6: stop mid-byte drops the partial byte
    do_start(); send_byte({DEV, 1'b0}, ak);
    send_byte(8'h01, ak); send_bits(8'hEE, 4); do_stop(); tick(4);
    exp_r[0] = 8'h01;
    check_regs("R6 partial byte");

    // R1: repeated start returns pointer to register 0
    do_start(); send_byte({DEV, 1'b0}, ak); send_byte(8'h00, ak); send_byte(8'h77, ak);
    do_start(); send_byte({DEV, 1'b0}, ak); send_byte(8'h03, ak); do_stop(); tick(4);
    exp_r[0] = 8'h03; exp_r[1] = 8'h77;
    check_regs("R1 repeated start");

    // Random transfers: R2 R3 R4 R5 R7 R8
    for (int t = 0; t < 40; t++) begin
      logic [6:0] a = ($urandom % 4 != 0) ? DEV : 7'($urandom);
      logic       rw = ($urandom % 8 == 0);
      int         len = $urandom % 7;
      bit         good = (a == DEV) && !rw;
      do_start(); send_byte({a, rw}, ak);
      check(ak == good, "R2 R3 random addr ack", ak, good);
      for (int i = 0; i < len; i++) begin
        logic [7:0] d = 8'($urandom);
        send_byte(d, ak);
        check(ak == good, "R5 random data ack", ak, good);
        if (good && i < N) exp_r[i] = d & keep_bits(i);
      end
      do_stop(); tick(4);
      check_regs("R4 R8 random regs");
    end

    // R11: no pull-low seen while master drove bits
    check(!stray, "R11 no drive in data bits", stray, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule